// File: doc/BRIEF.md
# Masked Array Access Request Decoder

This block sits at the request input of a search co-processor and carries out one request word per cycle. It first decides whether the request is meant for this device. The 8-bit device field is compared with a 3-bit strapped identity, and it also matches an all-ones broadcast code. The block then routes the access to one of four targets: the internal register file, the data array, the mask array, or an external SRAM port. The access address is either taken from the request itself or fetched from one of eight search result registers.

Writes to the two arrays are merged bit by bit under a selected global write mask, or they are written in full. Reads return their data one cycle after acceptance. A drive-enable output tells the cascade whether this device may put its read data on the shared bus. When a read is broadcast, only the device strapped to identity 0 drives. A separate configuration port preloads the search result registers and the three global write masks.

Top module: `arr_req_unit`

## Requirements
- R1: A request with `req_valid` high is accepted when bits 33:26 equal `{5'b0, dev_strap}` or equal 8'hFF. A request carrying another device's identity (0..7 but not `dev_strap`) changes no storage and produces no read response.
- R2: A device field of 8..254 is reserved. Such a request changes no storage and produces no read response.
- R3: For an accepted read, `rd_drive_en` is high with `rd_valid` when the device field matched `dev_strap`. For a broadcast read (8'hFF), `rd_drive_en` is high only if `dev_strap` is 0, while `rd_valid` still pulses. `rd_drive_en` is never high without `rd_valid`.
- R4: Bits 25:24 pick the target: 00 selects the internal register file (index = address bits 3:0), 01 the data array, 10 the mask array, and 11 the external SRAM. The arrays are indexed by address bits 5:0.
- R5: Bits 23:22 pick the array write mask: 00 selects mask register 0, 01 mask register 1, 10 mask register 2, and 11 selects a full-word write. Register-file writes are always full-word.
- R6: An array write stores (old AND NOT mask) OR (data AND mask) in a single cycle.
- R7: With bit 21 at 0, the address is bits 14:0 of the request.
- R8: With bit 21 at 1, the address is the search result register named by bits 20:17 (codes 0..7). Codes 8..15 are reserved, and such an indirect request is ignored like R2.
- R9: Bits 23:22 have no effect on reads. Bits 20:17 have no effect (a reserved code included) when bit 21 is 0.
- R10: An accepted read raises `rd_valid` for exactly the cycle after the request cycle, with `rd_data` holding the target word. Requests may be issued back to back.
- R11: When `cfg_we` is high, `cfg_sel` 0..7 loads search result register n with `cfg_data[14:0]`, and `cfg_sel` 8, 9 and 10 load mask registers 0, 1 and 2. `cfg_sel` 11..15 changes nothing.
- R12: An accepted SRAM access raises `sram_req` in the request cycle, with `sram_addr` set to the resolved address, `sram_we` set to the write flag and `sram_wdata` carrying the unmasked request data. For a read, the `sram_rdata` value present in that cycle is returned on `rd_data`.
- R13: After a synchronous reset, `rd_valid` and `rd_drive_en` are low and all search result registers and mask registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_strap | input | 3 | Strapped device identity |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 34 | Request control word |
| req_data | input | DATA_W | Write data |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | DATA_W | Configuration load value |
| sram_req | output | 1 | External SRAM access strobe |
| sram_we | output | 1 | External SRAM write flag |
| sram_addr | output | 15 | External SRAM address |
| sram_wdata | output | DATA_W | External SRAM write data |
| sram_rdata | input | DATA_W | External SRAM read data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DATA_W | Read response data |
| rd_drive_en | output | 1 | Permission to drive the shared read bus |

## Verification
Writes are tried with all four mask selections over known contents. Because the three mask patterns differ, a wrong register choice or a wrong merge shows up in the read-back word. Each target is reached with both direct and indirect addresses, including an unloaded result register after reset, which separates the address path from the target mux. Identity patterns cover own, foreign, reserved and broadcast codes under strap values 3 and 0, which separates acceptance from drive permission. Back-to-back reads, with the arrival cycle checked by the scoreboard, separate correct latency from late or merged responses.

// File: rtl/arr_req_pkg.sv
// Shared field positions and target encoding for the request decoder.
package arr_req_pkg;
    localparam int REQ_W    = 34;
    localparam int ADDR_W   = 15;
    localparam int DEV_LSB  = 26;
    localparam int ACC_LSB  = 24;
    localparam int WM_LSB   = 22;
    localparam int IND_BIT  = 21;
    localparam int RSEL_LSB = 17;
    localparam int N_RPTR   = 8;
    localparam int N_WMASK  = 3;
    localparam logic [7:0] DEV_ALL = 8'hFF;

    typedef enum logic [1:0] {
        ACC_REG  = 2'b00,
        ACC_DATA = 2'b01,
        ACC_MASK = 2'b10,
        ACC_SRAM = 2'b11
    } acc_t;
endpackage

// File: rtl/cfg_regs.sv
// Holds the eight search result registers and three global write masks.
// Assumes DATA_W >= ADDR_W; loads are single-cycle, reserved selects ignored.
module cfg_regs
    import arr_req_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [3:0]                        cfg_sel,
    input  logic [DATA_W-1:0]                 cfg_data,
    output logic [N_RPTR-1:0][ADDR_W-1:0]     rptr,
    output logic [N_WMASK-1:0][DATA_W-1:0]    wmask
);
    // Load one result register per cycle when selected.
    for (genvar g = 0; g < N_RPTR; g++) begin : g_rptr
        always_ff @(posedge clk) begin
            if (!rst_n)
                rptr[g] <= '0;
            else if (cfg_we && cfg_sel == 4'(g))
                rptr[g] <= cfg_data[ADDR_W-1:0];
        end
    end

    // Load one mask register per cycle when selected (codes 8..10).
    for (genvar g = 0; g < N_WMASK; g++) begin : g_wmask
        always_ff @(posedge clk) begin
            if (!rst_n)
                wmask[g] <= '0;
            else if (cfg_we && cfg_sel == 4'(8 + g))
                wmask[g] <= cfg_data;
        end
    end

    // R11
    reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel > 4'd10) |=> ($stable(rptr) && $stable(wmask)));
endmodule

// File: rtl/req_decode.sv
// Combinational decode of one request word: acceptance, target, resolved
// address and write mask. Assumes the register inputs are already stable.
module req_decode
    import arr_req_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                           req_valid,
    input  logic [REQ_W-1:0]               req_word,
    input  logic [2:0]                     dev_strap,
    input  logic [N_RPTR-1:0][ADDR_W-1:0]  rptr,
    input  logic [N_WMASK-1:0][DATA_W-1:0] wmask,
    output logic                           hit,
    output logic                           bcast,
    output acc_t                           acc,
    output logic [ADDR_W-1:0]              addr,
    output logic [DATA_W-1:0]              mask
);
    logic [7:0] dev;
    logic       own;
    logic       ind;
    logic [3:0] rsel;
    logic [1:0] wsel;
    logic       unused_bits;

    assign dev  = req_word[DEV_LSB +: 8];
    assign ind  = req_word[IND_BIT];
    assign rsel = req_word[RSEL_LSB +: 4];
    assign wsel = req_word[WM_LSB +: 2];
    assign acc  = acc_t'(req_word[ACC_LSB +: 2]);
    assign unused_bits = ^req_word[RSEL_LSB-1:ADDR_W];

    // Identity match and overall acceptance.
    always_comb begin
        own   = (dev == {5'b0, dev_strap});
        bcast = (dev == DEV_ALL);
        hit   = req_valid && (own || bcast) && (!ind || !rsel[3]);
    end

    // Direct or indirect address source.
    always_comb begin
        addr = ind ? rptr[rsel[2:0]] : req_word[ADDR_W-1:0];
    end

    // Write mask choice; code 3 is a full-word write.
    always_comb begin
        case (wsel)
            2'd0:    mask = wmask[0];
            2'd1:    mask = wmask[1];
            2'd2:    mask = wmask[2];
            default: mask = '1;
        endcase
    end
endmodule

// File: rtl/masked_store.sv
// Word storage with a bit-masked single-cycle read-modify-write and an
// asynchronous read of the addressed word. Contents are not reset.
module masked_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Merge masked bits of the write data into the stored word.
    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= (mem[idx] & ~wmask) | (wdata & wmask);
    end

    assign rdata = mem[idx];

    // R6
    keep_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(idx)] & ~$past(wmask)) == ($past(rdata) & ~$past(wmask))));
    // R6
    take_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(idx)] & $past(wmask)) == ($past(wdata) & $past(wmask))));
endmodule

// File: rtl/arr_req_unit.sv
// Top: decodes a request, performs the register/array/SRAM access and
// returns read data one cycle later with a cascade drive enable.
// Assumes SRAM read data is valid in the same cycle as sram_req.
module arr_req_unit
    import arr_req_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ARR_DEPTH = 64,
    parameter int REG_DEPTH = 16,
    localparam int AIDX_W   = $clog2(ARR_DEPTH),
    localparam int RIDX_W   = $clog2(REG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        dev_strap,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REQ_W-1:0]  req_word,
    input  logic [DATA_W-1:0] req_data,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              sram_req,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive_en
);
    logic [N_RPTR-1:0][ADDR_W-1:0]  rptr;
    logic [N_WMASK-1:0][DATA_W-1:0] wmask;
    logic                           hit, bcast;
    acc_t                           acc;
    logic [ADDR_W-1:0]              addr;
    logic [DATA_W-1:0]              mask;
    logic                           rd_go;
    logic [1:0]                     arr_we;
    logic [1:0][DATA_W-1:0]         arr_rd;
    logic                           reg_we;
    logic [DATA_W-1:0]              reg_rd;
    logic [DATA_W-1:0]              rd_src;

    cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .rptr(rptr), .wmask(wmask)
    );

    req_decode #(.DATA_W(DATA_W)) u_dec (
        .req_valid(req_valid), .req_word(req_word), .dev_strap(dev_strap),
        .rptr(rptr), .wmask(wmask), .hit(hit), .bcast(bcast), .acc(acc),
        .addr(addr), .mask(mask)
    );

    // Per-target write strobes and read start.
    always_comb begin
        rd_go     = hit && !req_write;
        arr_we[0] = hit && req_write && (acc == ACC_DATA);
        arr_we[1] = hit && req_write && (acc == ACC_MASK);
        reg_we    = hit && req_write && (acc == ACC_REG);
    end

    // Index 0 is the data array, index 1 the mask array.
    for (genvar g = 0; g < 2; g++) begin : g_arr
        masked_store #(.DEPTH(ARR_DEPTH), .DATA_W(DATA_W)) u_arr (
            .clk(clk), .rst_n(rst_n), .we(arr_we[g]), .idx(addr[AIDX_W-1:0]),
            .wdata(req_data), .wmask(mask), .rdata(arr_rd[g])
        );
    end

    masked_store #(.DEPTH(REG_DEPTH), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(addr[RIDX_W-1:0]),
        .wdata(req_data), .wmask({DATA_W{1'b1}}), .rdata(reg_rd)
    );

    // External SRAM strobes follow the decoded request in the same cycle.
    always_comb begin
        sram_req   = hit && (acc == ACC_SRAM);
        sram_we    = req_write;
        sram_addr  = addr;
        sram_wdata = req_data;
    end

    // Pick the read source for the target.
    always_comb begin
        case (acc)
            ACC_REG:  rd_src = reg_rd;
            ACC_DATA: rd_src = arr_rd[0];
            ACC_MASK: rd_src = arr_rd[1];
            default:  rd_src = sram_rdata;
        endcase
    end

    // Register the read response and the cascade drive permission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_drive_en <= 1'b0;
            rd_data     <= '0;
        end else begin
            rd_valid    <= rd_go;
            rd_drive_en <= rd_go && (!bcast || dev_strap == 3'd0);
            if (rd_go)
                rd_data <= rd_src;
        end
    end

    // R3
    drive_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive_en |-> rd_valid);
    // R1
    reject_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |=> !rd_valid);
    // R10
    resp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));
    // R12
    sram_only_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_req |-> req_valid);
endmodule

// File: tb/arr_req_unit_tb.sv
`timescale 1ns/1ps
module arr_req_unit_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    dev_strap;
    logic          req_valid, req_write;
    logic [33:0]   req_word;
    logic [DW-1:0] req_data;
    logic          cfg_we;
    logic [3:0]    cfg_sel;
    logic [DW-1:0] cfg_data;
    logic          sram_req, sram_we;
    logic [14:0]   sram_addr;
    logic [DW-1:0] sram_wdata, sram_rdata;
    logic          rd_valid, rd_drive_en;
    logic [DW-1:0] rd_data;

    always #2.5 clk = ~clk;

    assign sram_rdata = {17'h15A5A, sram_addr};

    arr_req_unit u_dut (
        .clk(clk), .rst_n(rst_n), .dev_strap(dev_strap), .req_valid(req_valid),
        .req_write(req_write), .req_word(req_word), .req_data(req_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_drive_en(rd_drive_en)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state, built from the requirements.
    logic [DW-1:0] m_data [64];
    logic [DW-1:0] m_mask [64];
    logic [DW-1:0] m_reg  [16];
    logic [14:0]   m_rptr [8];
    logic [DW-1:0] m_wm   [3];

    // Scoreboard queues: data, drive flag, arrival cycle, requirement tag.
    logic [DW-1:0] q_d [$];
    bit            q_v [$];
    int            q_c [$];
    string         q_t [$];

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares each read response with the queue head.
    always @(posedge clk) begin
        #1;
        if (rd_valid) begin
            if (q_d.size() == 0) begin
                check(0, "R1/R2 spurious rd_valid", 32'd1, 32'd0);
            end else begin
                check(q_c[0] == cyc, {q_t[0], " latency R10"}, cyc, q_c[0]);
                check(rd_data == q_d[0], {q_t[0], " data"}, rd_data, q_d[0]);
                check(rd_drive_en == q_v[0], {q_t[0], " drive R3"}, 32'(rd_drive_en), 32'(q_v[0]));
                void'(q_d.pop_front()); void'(q_v.pop_front());
                void'(q_c.pop_front()); void'(q_t.pop_front());
            end
        end else if (q_c.size() != 0 && q_c[0] <= cyc) begin
            check(0, {q_t[0], " missing response R10"}, 32'd0, 32'd1);
            void'(q_d.pop_front()); void'(q_v.pop_front());
            void'(q_c.pop_front()); void'(q_t.pop_front());
        end
        if (rd_drive_en && !rd_valid)
            check(0, "R3 drive without valid", 32'd1, 32'd0);
    end

    task automatic cfg(input logic [3:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
        if (sel < 8) m_rptr[sel[2:0]] = d[14:0];
        else if (sel < 11) m_wm[sel - 8] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: one request per cycle; updates the model and pushes expectations.
    task automatic issue(input string tag, input logic [7:0] dev, input logic [1:0] acc,
                         input logic [1:0] wm, input logic ind, input logic [3:0] rs,
                         input logic [14:0] a, input logic wr, input logic [DW-1:0] d);
        bit            acc_ok;
        logic [14:0]   ea;
        logic [DW-1:0] msk, expd;
        acc_ok = (dev == {5'b0, dev_strap} || dev == 8'hFF) && (!ind || rs < 8);
        ea  = ind ? m_rptr[rs[2:0]] : a;
        msk = (wm == 2'd3) ? '1 : m_wm[wm];
        req_valid = 1'b1; req_write = wr; req_data = d;
        req_word = {dev, acc, wm, ind, rs, 2'b00, a};
        if (acc_ok && wr) begin
            case (acc)
                2'd0: m_reg[ea[3:0]]  = d;
                2'd1: m_data[ea[5:0]] = (m_data[ea[5:0]] & ~msk) | (d & msk);
                2'd2: m_mask[ea[5:0]] = (m_mask[ea[5:0]] & ~msk) | (d & msk);
                default: ;
            endcase
        end
        if (acc_ok && !wr) begin
            case (acc)
                2'd0: expd = m_reg[ea[3:0]];
                2'd1: expd = m_data[ea[5:0]];
                2'd2: expd = m_mask[ea[5:0]];
                default: expd = {17'h15A5A, ea};
            endcase
            q_d.push_back(expd);
            q_v.push_back(dev != 8'hFF || dev_strap == 3'd0);
            q_c.push_back(cyc + 1);
            q_t.push_back(tag);
        end
        #1;
        check(sram_req == (acc_ok && acc == 2'd3), {tag, " sram_req R12"},
              32'(sram_req), 32'(acc_ok && acc == 2'd3));
        if (acc_ok && acc == 2'd3) begin
            check(sram_addr == ea && sram_we == wr && sram_wdata == d,
                  {tag, " sram fields R12"}, {16'(sram_we), 1'b0, sram_addr}, {16'(wr), 1'b0, ea});
        end
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_rptr[i] = '0;
        for (int i = 0; i < 3; i++) m_wm[i] = '0;
        rst_n = 1'b0; dev_strap = 3'd3; req_valid = 0; req_write = 0;
        req_word = '0; req_data = '0; cfg_we = 0; cfg_sel = '0; cfg_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R13 reset state of the outputs
        check(!rd_valid && !rd_drive_en, "R13 reset outputs", {rd_valid, rd_drive_en}, 0);
        check(!sram_req, "R13 sram idle", 32'(sram_req), 0);
        @(negedge clk);

        // R13 unloaded result register resolves to address 0
        issue("R4 full write data[0]", 8'd3, 2'd1, 2'd3, 0, 4'd0, 15'd0, 1, 32'h1111_1111);
        issue("R13 indirect via cleared reg", 8'd3, 2'd1, 2'd0, 1, 4'd5, 15'd9, 0, '0);
        idle();

        // R11 configuration loads
        cfg(4'd2, 32'd10);
        cfg(4'd8, 32'h0000_FFFF);
        cfg(4'd9, 32'hFF00_FF00);
        cfg(4'd10, 32'hF0F0_F0F0);
        cfg(4'd12, 32'h1234_5678);

        issue("R4 fill data[10]", 8'd3, 2'd1, 2'd3, 0, 4'd0, 15'd10, 1, 32'hAAAA_AAAA);
        issue("R4 fill data[7]",  8'd3, 2'd1, 2'd3, 0, 4'd0, 15'd7,  1, 32'h1234_5678);
        issue("R4 fill mask[10]", 8'd3, 2'd2, 2'd3, 0, 4'd0, 15'd10, 1, 32'hDEAD_BEEF);
        issue("R4 fill reg[5]",   8'd3, 2'd0, 2'd1, 0, 4'd0, 15'd5,  1, 32'hCAFE_F00D);
        // R10 back-to-back reads, R7 direct
        issue("R7 read data[7]",  8'd3, 2'd1, 2'd0, 0, 4'd0, 15'd7,  0, '0);
        issue("R4 read mask[10]", 8'd3, 2'd2, 2'd0, 0, 4'd0, 15'd10, 0, '0);
        issue("R4 read reg[5]",   8'd3, 2'd0, 2'd0, 0, 4'd0, 15'd5,  0, '0);
        issue("R8 indirect data", 8'd3, 2'd1, 2'd0, 1, 4'd2, 15'd0,  0, '0);
        idle();

        // R5 R6 masked writes with each mask register
        issue("R5 wm0 write", 8'd3, 2'd1, 2'd0, 0, 4'd0, 15'd7,  1, 32'hFFFF_FFFF);
        issue("R5 wm1 write", 8'd3, 2'd2, 2'd1, 0, 4'd0, 15'd10, 1, 32'h0000_0000);
        issue("R8 wm2 indirect write", 8'd3, 2'd1, 2'd2, 1, 4'd2, 15'd0, 1, 32'h0F0F_0F0F);
        issue("R6 read data[7]",  8'd3, 2'd1, 2'd0, 0, 4'd0, 15'd7,  0, '0);
        issue("R6 read mask[10]", 8'd3, 2'd2, 2'd0, 0, 4'd0, 15'd10, 0, '0);
        // R9 mask field and reserved select ignored on direct read
        issue("R9 read data[10]", 8'd3, 2'd1, 2'd2, 0, 4'd15, 15'd10, 0, '0);
        issue("R11 reg-file write ignores mask R5", 8'd3, 2'd0, 2'd0, 0, 4'd0, 15'd5, 1, 32'h0BAD_0BAD);
        issue("R5 read reg[5]", 8'd3, 2'd0, 2'd0, 0, 4'd0, 15'd5, 0, '0);
        idle();

        // R1 R2 R8 ignored requests
        issue("R2 reserved id write", 8'h80, 2'd1, 2'd3, 0, 4'd0, 15'd7, 1, 32'h0);
        issue("R2 reserved id read",  8'hFE, 2'd1, 2'd3, 0, 4'd0, 15'd7, 0, '0);
        issue("R1 other device write", 8'd2, 2'd1, 2'd3, 0, 4'd0, 15'd7, 1, 32'h0);
        issue("R1 other device read",  8'd2, 2'd2, 2'd3, 0, 4'd0, 15'd7, 0, '0);
        issue("R8 reserved rsel write", 8'd3, 2'd1, 2'd3, 1, 4'd9, 15'd7, 1, 32'h0);
        issue("R2 read data[7] unchanged", 8'd3, 2'd1, 2'd0, 0, 4'd0, 15'd7, 0, '0);
        idle();

        // R3 broadcast behaviour from a nonzero strap
        issue("R3 bcast write", 8'hFF, 2'd2, 2'd3, 0, 4'd0, 15'd3, 1, 32'h5555_AAAA);
        issue("R3 bcast read strap3", 8'hFF, 2'd2, 2'd0, 0, 4'd0, 15'd3, 0, '0);
        idle();
        dev_strap = 3'd0;
        @(negedge clk);
        issue("R3 bcast read strap0", 8'hFF, 2'd2, 2'd0, 0, 4'd0, 15'd3, 0, '0);
        issue("R1 own read strap0",   8'd0,  2'd1, 2'd0, 0, 4'd0, 15'd7, 0, '0);
        idle();

        // R12 external SRAM
        issue("R12 sram write", 8'd0, 2'd3, 2'd0, 0, 4'd0, 15'h1234, 1, 32'h7777_8888);
        issue("R12 sram read",  8'd0, 2'd3, 2'd1, 0, 4'd0, 15'h4321, 0, '0);
        issue("R12 sram indirect read", 8'd0, 2'd3, 2'd0, 1, 4'd2, 15'd0, 0, '0);
        issue("R12 sram other device", 8'd5, 2'd3, 2'd0, 0, 4'd0, 15'd1, 0, '0);
        idle();
        repeat (3) @(negedge clk);
        check(q_d.size() == 0, "R10 outstanding responses", q_d.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule